// File: doc/BRIEF.md
# Two-Wire Wiper Command Slave

This block is the serial front end of a four-channel wiper controller. It watches a two-wire bus (clock line and open-drain data line) through the system clock. It finds start and stop conditions and checks the slave address against a fixed type code and four strap inputs. It then takes an instruction byte that names an operation, one of four channels and one of four stored registers. Depending on the operation, the block either ends the frame or moves one data byte in or out.

The block never writes storage itself. Operations that change state are handed on as a single-cycle strobe carrying opcode, channel, register and data. That strobe is raised only when the closing stop arrives, so a frame cut short by a new start leaves nothing behind. One operation opens a streaming mode. In that mode each further clock pulse produces a one-step move of the selected wiper, upward or downward by the data line level. A busy input from the storage side withholds the address acknowledge, so the master can poll until a slow write has finished.

Top module: `twpot_cmd_slave`

## Requirements
- R1: While and after reset, the data-line pull-down `sda_oe_o`, `cmd_valid_o` and `step_valid_o` are all low.
- R2: The first byte after a start (received MSB first, sampled on clock rise) is acknowledged by pulling the data line low in the ninth clock only when its upper nibble is 0101 and its lower nibble equals `dev_addr_i`. Otherwise the block ignores the bus until the next start, and a later stop gives no strobe.
- R3: While `nv_busy_i` is high at the end of the address byte, the address is not acknowledged, even when it matches.
- R4: The instruction byte is split as opcode in bits 7:4, channel in bits 3:2 and register in bits 1:0, and it is acknowledged for any of the nine opcodes 0001, 0010, 1000, 1001, 1010, 1011, 1100, 1101, 1110. For opcodes 1101, 1110, 0001 and 1000 the frame then ends, and the stop raises `cmd_valid_o` with those fields on `cmd_op_o`, `cmd_pot_o` and `cmd_reg_o`.
- R5: For opcodes 1010 and 1100 a third byte is received and acknowledged, and the stop raises `cmd_valid_o` with that byte on `cmd_data_o`.
- R6: For opcodes 1001 and 1011, `rd_data_i` is captured when the instruction acknowledge ends and sent MSB first, each bit changing only while the clock is low. The data line is then released for the master's acknowledge, and the stop gives no strobe.
- R7: After opcode 0010 is acknowledged, each later clock pulse that falls gives one `step_valid_o` pulse, with `step_up_o` set to the data level seen at that pulse's rising edge (1 = toward the high end). The clock rise that belongs to the stop gives no step, and the stop gives no `cmd_valid_o`.
- R8: An instruction byte with any other opcode is not acknowledged and produces no strobe.
- R9: A start at any point abandons the frame in progress and restarts address matching. Only a frame that completes is strobed.
- R10: `cmd_valid_o` is a single-cycle pulse and is raised only in the cycle after a stop is detected.
- R11: `step_valid_o` pulses only in streaming mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dev_addr_i | input | 4 | Device address straps |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe_o | output | 1 | 1 pulls the data line low |
| nv_busy_i | input | 1 | Storage write in progress |
| rd_data_i | input | 8 | Read value for the selected channel and register |
| cmd_valid_o | output | 1 | Command strobe, one cycle |
| cmd_op_o | output | 4 | Opcode of the last instruction |
| cmd_pot_o | output | 2 | Channel select |
| cmd_reg_o | output | 2 | Register select |
| cmd_data_o | output | 8 | Received data byte |
| step_valid_o | output | 1 | One-step wiper move strobe |
| step_up_o | output | 1 | Direction of the step, 1 = up |

## Verification
The assertions assume a well-behaved master on a wired-AND data line. That means the data line changes only while the clock is low, except at starts and stops. It also means no start or stop is attempted while the block holds the line low, and clock phases last several system cycles. The bench models the line as the master level ANDed with the block's pull-down. It holds each clock phase for twelve cycles and moves data a couple of cycles after each clock fall, so every edge reaches the synchronizers cleanly and the one-sided timing relations in the checks apply.

// File: rtl/twpot_pkg.sv
package twpot_pkg;
  localparam int BITS   = 8;
  localparam int CNT_W  = 4;
  localparam logic [3:0] TYPE_CODE = 4'b0101;

  localparam logic [3:0] OP_LOAD_ALL = 4'b0001;
  localparam logic [3:0] OP_STEP     = 4'b0010;
  localparam logic [3:0] OP_SAVE_ALL = 4'b1000;
  localparam logic [3:0] OP_RD_WIPER = 4'b1001;
  localparam logic [3:0] OP_WR_WIPER = 4'b1010;
  localparam logic [3:0] OP_RD_REG   = 4'b1011;
  localparam logic [3:0] OP_WR_REG   = 4'b1100;
  localparam logic [3:0] OP_LOAD_ONE = 4'b1101;
  localparam logic [3:0] OP_SAVE_ONE = 4'b1110;

  typedef enum logic [3:0] {
    ST_IDLE, ST_ADDR, ST_ADDR_ACK, ST_INSTR, ST_INSTR_ACK,
    ST_WDATA, ST_WDATA_ACK, ST_RDATA, ST_RACK, ST_PEND, ST_STEP
  } fsm_e;

  function automatic logic cmd_short(input logic [3:0] op);
    return op == OP_LOAD_ONE || op == OP_SAVE_ONE ||
           op == OP_LOAD_ALL || op == OP_SAVE_ALL;
  endfunction

  function automatic logic cmd_write(input logic [3:0] op);
    return op == OP_WR_WIPER || op == OP_WR_REG;
  endfunction

  function automatic logic cmd_read(input logic [3:0] op);
    return op == OP_RD_WIPER || op == OP_RD_REG;
  endfunction

  function automatic logic cmd_legal(input logic [3:0] op);
    return cmd_short(op) || cmd_write(op) || cmd_read(op) || op == OP_STEP;
  endfunction
endpackage

// File: rtl/twpot_sync.sv
module twpot_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [STAGES-1:0][WIDTH-1:0] pipe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe[0] <= RST_VAL;
    else        pipe[0] <= d;
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe[g] <= RST_VAL;
      else        pipe[g] <= pipe[g-1];
    end
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/twpot_bus_cond.sv
module twpot_bus_cond (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s,
  input  logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/twpot_frame_ctrl.sv
module twpot_frame_ctrl
  import twpot_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sda_s,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       start_det,
  input  logic       stop_det,
  input  logic [3:0] dev_addr_i,
  input  logic       nv_busy_i,
  input  logic [7:0] rd_data_i,
  output logic       sda_oe,
  output logic       cmd_valid_o,
  output logic [3:0] cmd_op_o,
  output logic [1:0] cmd_pot_o,
  output logic [1:0] cmd_reg_o,
  output logic [7:0] cmd_data_o,
  output logic       step_valid_o,
  output logic       step_up_o
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(BITS);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BITS - 1);

  fsm_e             st, st_n;
  logic [CNT_W-1:0] cnt, cnt_n;
  logic [7:0]       sh, sh_n, dat, dat_n;
  logic [3:0]       op, op_n;
  logic [1:0]       pot, pot_n, rs, rs_n;
  logic             oe_n, arm, arm_n, dir, dir_n, cv_n, sv_n, up, up_n;
  logic             byte_done;

  assign byte_done = scl_fall && (cnt == FULL);

  always_comb begin
    st_n = st; cnt_n = cnt; sh_n = sh; dat_n = dat; op_n = op; pot_n = pot;
    rs_n = rs; oe_n = sda_oe; arm_n = arm; dir_n = dir; up_n = up;
    cv_n = 1'b0; sv_n = 1'b0;
    if (start_det) begin
      st_n = ST_ADDR; cnt_n = '0; oe_n = 1'b0; arm_n = 1'b0;
    end else if (stop_det) begin
      st_n = ST_IDLE; oe_n = 1'b0; arm_n = 1'b0; cv_n = (st == ST_PEND);
    end else begin
      case (st)
        ST_ADDR, ST_INSTR, ST_WDATA: begin
          if (scl_rise && cnt != FULL) begin
            sh_n  = {sh[6:0], sda_s};
            cnt_n = cnt + 1'b1;
          end else if (byte_done) begin
            cnt_n = '0;
            if (st == ST_ADDR) begin
              if (sh == {TYPE_CODE, dev_addr_i} && !nv_busy_i) begin
                oe_n = 1'b1; st_n = ST_ADDR_ACK;
              end else st_n = ST_IDLE;
            end else if (st == ST_INSTR) begin
              op_n = sh[7:4]; pot_n = sh[3:2]; rs_n = sh[1:0];
              if (cmd_legal(sh[7:4])) begin
                oe_n = 1'b1; st_n = ST_INSTR_ACK;
              end else st_n = ST_IDLE;
            end else begin
              dat_n = sh; oe_n = 1'b1; st_n = ST_WDATA_ACK;
            end
          end
        end
        ST_ADDR_ACK: if (scl_fall) begin oe_n = 1'b0; st_n = ST_INSTR; end
        ST_INSTR_ACK: if (scl_fall) begin
          oe_n = 1'b0;
          if (cmd_short(op))      st_n = ST_PEND;
          else if (cmd_write(op)) st_n = ST_WDATA;
          else if (cmd_read(op)) begin
            st_n = ST_RDATA; sh_n = rd_data_i; oe_n = ~rd_data_i[7]; cnt_n = '0;
          end else begin
            st_n = ST_STEP; arm_n = 1'b0;
          end
        end
        ST_WDATA_ACK: if (scl_fall) begin oe_n = 1'b0; st_n = ST_PEND; end
        ST_RDATA: if (scl_fall) begin
          if (cnt == LAST) begin
            oe_n = 1'b0; st_n = ST_RACK;
          end else begin
            cnt_n = cnt + 1'b1; sh_n = {sh[6:0], 1'b0}; oe_n = ~sh[6];
          end
        end
        ST_RACK: if (scl_fall) st_n = ST_IDLE;
        ST_STEP: begin
          if (scl_rise) begin
            dir_n = sda_s; arm_n = 1'b1;
          end else if (scl_fall && arm) begin
            sv_n = 1'b1; up_n = dir; arm_n = 1'b0;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; cnt <= '0; sh <= '0; dat <= '0; op <= '0; pot <= '0;
      rs <= '0; sda_oe <= 1'b0; arm <= 1'b0; dir <= 1'b0; up <= 1'b0;
      cmd_valid_o <= 1'b0; step_valid_o <= 1'b0;
    end else begin
      st <= st_n; cnt <= cnt_n; sh <= sh_n; dat <= dat_n; op <= op_n;
      pot <= pot_n; rs <= rs_n; sda_oe <= oe_n; arm <= arm_n; dir <= dir_n;
      up <= up_n; cmd_valid_o <= cv_n; step_valid_o <= sv_n;
    end
  end

  assign cmd_op_o   = op;
  assign cmd_pot_o  = pot;
  assign cmd_reg_o  = rs;
  assign cmd_data_o = dat;
  assign step_up_o  = up;

  p_strobe_after_stop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid_o |-> $past(stop_det));
  p_strobe_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid_o |=> !cmd_valid_o);
  p_step_on_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    step_valid_o |-> $past(scl_fall));
  p_step_mode_only_r11: assert property (@(posedge clk) disable iff (!rst_n)
    step_valid_o |-> $past(st == ST_STEP));
  p_busy_noack_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_ADDR && byte_done && nv_busy_i && !start_det && !stop_det) |=> !sda_oe);
endmodule

// File: rtl/twpot_cmd_slave.sv
module twpot_cmd_slave #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] dev_addr_i,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe_o,
  input  logic       nv_busy_i,
  input  logic [7:0] rd_data_i,
  output logic       cmd_valid_o,
  output logic [3:0] cmd_op_o,
  output logic [1:0] cmd_pot_o,
  output logic [1:0] cmd_reg_o,
  output logic [7:0] cmd_data_o,
  output logic       step_valid_o,
  output logic       step_up_o
);
  logic [1:0] rst_pipe;
  logic       rst_core_n;
  logic [1:0] line_s;
  logic       scl_rise, scl_fall, start_det, stop_det;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_core_n = rst_pipe[1];

  twpot_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) u_sync (
    .clk(clk), .rst_n(rst_core_n), .d({scl_i, sda_i}), .q(line_s));

  twpot_bus_cond u_cond (
    .clk(clk), .rst_n(rst_core_n), .scl_s(line_s[1]), .sda_s(line_s[0]),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det));

  twpot_frame_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_core_n), .sda_s(line_s[0]),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det),
    .dev_addr_i(dev_addr_i), .nv_busy_i(nv_busy_i), .rd_data_i(rd_data_i),
    .sda_oe(sda_oe_o), .cmd_valid_o(cmd_valid_o), .cmd_op_o(cmd_op_o),
    .cmd_pot_o(cmd_pot_o), .cmd_reg_o(cmd_reg_o), .cmd_data_o(cmd_data_o),
    .step_valid_o(step_valid_o), .step_up_o(step_up_o));

  p_oe_moves_clock_low_r6: assert property (@(posedge clk) disable iff (!rst_core_n)
    !$stable(sda_oe_o) |-> !line_s[1]);
  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_core_n |-> (!sda_oe_o && !cmd_valid_o && !step_valid_o));
endmodule

// File: tb/twpot_cmd_slave_tb.sv
`timescale 1ns/1ps
module twpot_cmd_slave_tb_top;
  localparam int H = 12;
  localparam logic [3:0] DEV = 4'hB;
  localparam logic [7:0] MY_ADDR = {4'b0101, DEV};
  localparam int NVEC = 12;
  // {address byte, instruction byte, data byte}
  localparam logic [23:0] VEC [NVEC] = '{
    24'h5B_D6_00, 24'h5B_E1_00, 24'h5B_1B_00, 24'h5B_8E_00,
    24'h5B_A4_C7, 24'h5B_CB_3F, 24'h5B_96_00, 24'h5B_B9_00,
    24'h5A_D0_00, 24'h7B_D0_00, 24'h5B_F0_00, 24'h5B_30_00
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1, m_sda = 1'b1, nv_busy = 1'b0;
  logic sda_line, sda_oe, cmd_valid, step_valid, step_up;
  logic [3:0] cmd_op;
  logic [1:0] cmd_pot, cmd_reg;
  logic [7:0] cmd_data, rd_data;
  int n_chk = 0, n_bad = 0, n_cmd = 0, n_step = 0, n_up = 0;
  logic [3:0] cap_op;
  logic [1:0] cap_pot, cap_reg;
  logic [7:0] cap_data;

  always #5 clk = ~clk;

  assign sda_line = m_sda & ~sda_oe;
  assign rd_data  = {cmd_pot, cmd_reg, cmd_op} ^ 8'hA5;

  twpot_cmd_slave dut_i (
    .clk(clk), .rst_n(rst_n), .dev_addr_i(DEV), .scl_i(scl), .sda_i(sda_line),
    .sda_oe_o(sda_oe), .nv_busy_i(nv_busy), .rd_data_i(rd_data),
    .cmd_valid_o(cmd_valid), .cmd_op_o(cmd_op), .cmd_pot_o(cmd_pot),
    .cmd_reg_o(cmd_reg), .cmd_data_o(cmd_data),
    .step_valid_o(step_valid), .step_up_o(step_up));

  always @(negedge clk) begin
    if (cmd_valid) begin
      n_cmd++; cap_op = cmd_op; cap_pot = cmd_pot; cap_reg = cmd_reg; cap_data = cmd_data;
    end
    if (step_valid) begin
      n_step++;
      if (step_up) n_up++;
    end
  end

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic half();
    repeat (H) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; half(); scl = 1'b1; half(); m_sda = 1'b0; half(); scl = 1'b0; half();
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; half(); scl = 1'b1; half(); m_sda = 1'b1; half();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; half(); scl = 1'b1; half(); scl = 1'b0;
      repeat (2) @(negedge clk);
    end
    m_sda = 1'b1; half(); scl = 1'b1;
    repeat (H/2) @(negedge clk);
    ack = ~sda_line;
    repeat (H/2) @(negedge clk);
    scl = 1'b0; repeat (2) @(negedge clk);
  endtask

  task automatic read_byte(output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      half(); scl = 1'b1;
      repeat (H/2) @(negedge clk);
      b[i] = sda_line;
      repeat (H/2) @(negedge clk);
      scl = 1'b0; repeat (2) @(negedge clk);
    end
    m_sda = 1'b1; half(); scl = 1'b1; half(); scl = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic step_pulse(input logic up);
    m_sda = up; half(); scl = 1'b1; half(); scl = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic ack;
    logic [7:0] rb;
    int c0, s0;
    // R1: reset state
    repeat (3) @(negedge clk);
    check(!sda_oe && !cmd_valid && !step_valid, "R1 during reset", sda_oe, 0);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    check(!sda_oe && !cmd_valid && !step_valid, "R1 after reset", sda_oe, 0);

    // table walk: R2 R4 R5 R6 R8 R10 R11
    for (int v = 0; v < NVEC; v++) begin
      logic [7:0] a, ins, d;
      logic [3:0] op;
      logic exp_ack;
      {a, ins, d} = VEC[v];
      op = ins[7:4];
      c0 = n_cmd; s0 = n_step;
      bus_start();
      send_byte(a, ack);
      check(ack == (a == MY_ADDR), "R2 address ack", ack, a == MY_ADDR);
      if (ack) begin
        exp_ack = op inside {4'b0001, 4'b0010, 4'b1000, 4'b1001, 4'b1010,
                             4'b1011, 4'b1100, 4'b1101, 4'b1110};
        send_byte(ins, ack);
        check(ack == exp_ack, exp_ack ? "R4 instruction ack" : "R8 illegal opcode no ack", ack, exp_ack);
        if (ack && op inside {4'b1010, 4'b1100}) begin
          send_byte(d, ack);
          check(ack, "R5 data byte ack", ack, 1);
        end else if (ack && op inside {4'b1001, 4'b1011}) begin
          read_byte(rb);
          check(rb == ({ins[3:2], ins[1:0], ins[7:4]} ^ 8'hA5), "R6 read data MSB first",
                rb, {ins[3:2], ins[1:0], ins[7:4]} ^ 8'hA5);
        end
        bus_stop();
        repeat (4) @(negedge clk);
        if (op inside {4'b1101, 4'b1110, 4'b0001, 4'b1000, 4'b1010, 4'b1100} && exp_ack) begin
          check(n_cmd == c0 + 1, "R10 single strobe at stop", n_cmd - c0, 1);
          check(cap_op == op && cap_pot == ins[3:2] && cap_reg == ins[1:0],
                "R4 strobe fields", {cap_op, cap_pot, cap_reg}, ins);
          if (op inside {4'b1010, 4'b1100})
            check(cap_data == d, "R5 strobe data", cap_data, d);
        end else begin
          check(n_cmd == c0, op[3] && exp_ack ? "R6 read gives no strobe" : "R8 no strobe",
                n_cmd - c0, 0);
        end
      end else begin
        bus_stop();
        repeat (4) @(negedge clk);
        check(n_cmd == c0, "R2 mismatched frame no strobe", n_cmd - c0, 0);
      end
      check(n_step == s0, "R11 no steps outside stream mode", n_step - s0, 0);
    end

    // R3: busy withholds address ack, then polling succeeds
    nv_busy = 1'b1;
    bus_start(); send_byte(MY_ADDR, ack); bus_stop();
    check(!ack, "R3 busy address not acked", ack, 0);
    nv_busy = 1'b0;
    c0 = n_cmd;
    bus_start(); send_byte(MY_ADDR, ack);
    check(ack, "R3 ack after busy clears", ack, 1);
    send_byte(8'hD0, ack); bus_stop(); repeat (4) @(negedge clk);
    check(n_cmd == c0 + 1, "R3 command after poll", n_cmd - c0, 1);

    // R7: streaming steps
    c0 = n_cmd; s0 = n_step;
    bus_start(); send_byte(MY_ADDR, ack); send_byte(8'h24, ack);
    check(ack && cmd_pot == 2'd1, "R7 stream opcode acked", {ack, cmd_pot}, 3'b101);
    check(n_step == s0, "R7 no step from ack pulse", n_step - s0, 0);
    step_pulse(1); step_pulse(1); step_pulse(0);
    step_pulse(1); step_pulse(0); step_pulse(0);
    check(n_step == s0 + 6, "R7 one step per pulse", n_step - s0, 6);
    bus_stop(); repeat (4) @(negedge clk);
    check(n_step == s0 + 6, "R7 stop adds no step", n_step - s0, 6);
    check(n_up == 3 + (s0 - s0), "R7 up count follows data level", n_up, 3);
    check(n_cmd == c0, "R7 stream stop gives no strobe", n_cmd - c0, 0);

    // R9: repeated start aborts the frame
    c0 = n_cmd;
    bus_start(); send_byte(MY_ADDR, ack); send_byte(8'hC5, ack);
    send_byte(8'h77, ack);
    bus_start(); send_byte(MY_ADDR, ack);
    check(ack, "R9 address rematched after restart", ack, 1);
    send_byte(8'hE2, ack); bus_stop(); repeat (4) @(negedge clk);
    check(n_cmd == c0 + 1 && cap_op == 4'hE && cap_reg == 2'd2,
          "R9 only completed frame strobed", {n_cmd - c0, cap_op}, 8'h1E);
    c0 = n_cmd;
    bus_start(); send_byte(MY_ADDR, ack); send_byte(8'hD1, ack);
    bus_start(); m_sda = 1'b1; half();
    scl = 1'b1; half(); half();
    bus_stop(); repeat (4) @(negedge clk);
    check(n_cmd == c0, "R9 abandoned command not strobed", n_cmd - c0, 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule